// File: doc/BRIEF.md
# Direct-mapped write-through word cache

This block sits between a processor load/store port and a slower word-wide memory. It keeps 1024 lines of one 32-bit word each, looked up by address bits [11:2]. Reads of byte, halfword or word size that hit a valid line are answered from the data array without involving memory. A read that misses fetches the aligned word from memory and installs it in the line. Every store is forwarded to memory. A cacheable word store also refreshes the line, and a cacheable byte or halfword store empties the line instead of merging into it.

Only a 2 MB address window is cached. Every other address, for example device registers or external RAM, passes straight to memory and leaves the arrays untouched. The processor issues one request at a time and waits while the ready output is low. The memory side carries one outstanding request, held until the memory acknowledges it.

Top module: `wt_word_cache`

## Requirements
- R1: After reset every line is empty, so the first read of any cacheable address misses. `cpu_ready` is high and `mem_req` is low.
- R2: An address is cacheable only when bits [31:20] equal 0x100 or 0x101. Every read of any other address goes to memory, and that read never installs a line.
- R3: The line index is address bits [11:2]. The stored tag is the 9-bit value {addr[20], addr[19:12]}. Two cacheable addresses with the same index and different tags evict each other.
- R4: On a read miss the cache raises `mem_req` with `mem_we`=0, `mem_size`=2 and a word-aligned `mem_addr`. `cpu_ready` stays low until the clock edge after `mem_ack`. The returned word is then delivered on `cpu_rdata` and installed in the line.
- R5: A read hit updates `cpu_rdata` at the clock edge that accepts the request, keeps `cpu_ready` high and raises no memory request.
- R6: Size codes are 0 for byte, 1 for halfword and 2 for word. With `big_endian`=0, a byte read returns bits [8*a+7:8*a] of the word, where a = addr[1:0]. A halfword read returns bits [16*addr[1]+15:16*addr[1]]. Sub-word results are zero-extended.
- R7: With `big_endian`=1, the low two address bits are XORed with 3 before the byte or halfword lane is chosen. Word reads are returned unchanged.
- R8: Every store, cacheable or not, raises `mem_req` with `mem_we`=1. The store carries the processor's address, size and write data unchanged. `cpu_ready` stays low until the edge after `mem_ack`.
- R9: A cacheable word store writes its tag and data into the line, so a following read of that word hits and returns the stored value.
- R10: A cacheable byte or halfword store empties its line, so the next read of that word misses and returns the merged word from memory.
- R11: Tag value 0x1FF is the empty marker. Cacheable addresses whose tag equals it (0x101FF000 to 0x101FFFFF) therefore miss on every read.
- R12: Only one memory request is outstanding at a time. `mem_req` and `mem_addr` hold steady until `mem_ack`, and `mem_req` is low in the cycle after `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Store data, value in the low bits |
| cpu_rd | input | 1 | Read request, taken while `cpu_ready` is high |
| cpu_wr | input | 1 | Store request, taken while `cpu_ready` is high; wins over `cpu_rd` |
| big_endian | input | 1 | Selects byte-lane ordering for sub-word reads |
| cpu_rdata | output | 32 | Read result, zero-extended for sub-word sizes |
| cpu_ready | output | 1 | High when idle and the last read result is valid |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a store, 0 for a word fetch |
| mem_addr | output | 32 | Memory address |
| mem_size | output | 2 | Size code of the memory access |
| mem_wdata | output | 32 | Store data to memory |
| mem_rdata | input | 32 | Word returned by memory, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the current request |

## Verification
A read hit has its result registered at the rising edge that accepts the request. The bench drives the request at a falling edge and reads `cpu_rdata` at the next falling edge, where `cpu_ready` is still high. Misses, bypassed reads and stores leave `cpu_ready` low from that edge until the rising edge after `mem_ack`. The bench waits falling edge by falling edge until `cpu_ready` returns, and only then takes the result and the memory-request count. Hit or miss is decided by whether the memory model saw a request during the access, and the expected word comes from the bench's own memory image and lane rules.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 10;
    localparam int IDX_LSB = 2;
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int WIN_LSB = 20;
    localparam int TAG_W   = WIN_LSB - TAG_LSB + 1;
    localparam int LINES   = 1 << IDX_W;

    localparam logic [ADDR_W-WIN_LSB-1:0] WIN_FIRST = 12'h100;
    localparam logic [ADDR_W-WIN_LSB-1:0] WIN_LAST  = 12'h101;
    localparam logic [TAG_W-1:0]          TAG_NONE  = '1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_STORE
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        size_e             size;
        logic              big;
    } rd_ctx_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_wr_t;

    function automatic logic in_window(logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:WIN_LSB] == WIN_FIRST) || (a[ADDR_W-1:WIN_LSB] == WIN_LAST);
    endfunction

    function automatic logic [IDX_W-1:0] line_idx(logic [ADDR_W-1:0] a);
        return a[TAG_LSB-1:IDX_LSB];
    endfunction

    function automatic logic [TAG_W-1:0] line_tag(logic [ADDR_W-1:0] a);
        return a[WIN_LSB:TAG_LSB];
    endfunction

    function automatic logic [DATA_W-1:0] lane_pick(logic [DATA_W-1:0] w, logic [1:0] lo,
                                                    size_e sz, logic big);
        logic [1:0] l;
        l = lo ^ {big, big};
        case (sz)
            SZ_BYTE: return {24'b0, w[{l, 3'b000} +: 8]};
            SZ_HALF: return {16'b0, w[{l[1], 4'b0000} +: 16]};
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/wtc_lines.sv
module wtc_lines
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  look_idx,
    output logic [TAG_W-1:0]  look_tag,
    output logic [DATA_W-1:0] look_data,
    input  line_wr_t          wr
);

    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                tag_mem[i] <= TAG_NONE;
            end
        end else if (wr.en) begin
            tag_mem[wr.idx] <= wr.tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr.en) begin
            data_mem[wr.idx] <= wr.data;
        end
    end

    assign look_tag  = tag_mem[look_idx];
    assign look_data = data_mem[look_idx];

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              big_endian,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [DATA_W-1:0] look_data,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output line_wr_t          line_wr
);

    state_e  state_q;
    rd_ctx_t ctx_q;
    logic    accept;
    logic    cacheable;
    logic    hit;
    size_e   req_size;

    assign req_size  = size_e'(cpu_size);
    assign accept    = (state_q == ST_IDLE) && (cpu_rd || cpu_wr);
    assign cacheable = in_window(cpu_addr);
    assign hit       = cacheable && (look_tag == line_tag(cpu_addr)) && (look_tag != TAG_NONE);
    assign cpu_ready = (state_q == ST_IDLE);

    always_comb begin
        line_wr = '0;
        if (accept && cpu_wr && cacheable) begin
            line_wr.en   = 1'b1;
            line_wr.idx  = line_idx(cpu_addr);
            line_wr.tag  = (req_size == SZ_WORD) ? line_tag(cpu_addr) : TAG_NONE;
            line_wr.data = cpu_wdata;
        end else if ((state_q == ST_FILL) && mem_ack && in_window(ctx_q.addr)) begin
            line_wr.en   = 1'b1;
            line_wr.idx  = line_idx(ctx_q.addr);
            line_wr.tag  = line_tag(ctx_q.addr);
            line_wr.data = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            cpu_rdata <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_size  <= SZ_WORD;
            mem_wdata <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept && cpu_wr) begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_addr  <= cpu_addr;
                        mem_size  <= cpu_size;
                        mem_wdata <= cpu_wdata;
                        state_q   <= ST_STORE;
                    end else if (accept && hit) begin
                        cpu_rdata <= lane_pick(look_data, cpu_addr[1:0], req_size, big_endian);
                    end else if (accept) begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b0;
                        mem_addr  <= {cpu_addr[ADDR_W-1:2], 2'b00};
                        mem_size  <= SZ_WORD;
                        ctx_q     <= '{addr: cpu_addr, size: req_size, big: big_endian};
                        state_q   <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        mem_req   <= 1'b0;
                        cpu_rdata <= lane_pick(mem_rdata, ctx_q.addr[1:0], ctx_q.size, ctx_q.big);
                        state_q   <= ST_IDLE;
                    end
                end
                ST_STORE: begin
                    if (mem_ack) begin
                        mem_req <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wt_word_cache.sv
module wt_word_cache
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [31:0]       cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              big_endian,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);

    logic [TAG_W-1:0]  look_tag;
    logic [DATA_W-1:0] look_data;
    line_wr_t          line_wr;

    wtc_lines u_lines (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (line_idx(cpu_addr)),
        .look_tag  (look_tag),
        .look_data (look_data),
        .wr        (line_wr)
    );

    wtc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_size   (cpu_size),
        .cpu_wdata  (cpu_wdata),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .big_endian (big_endian),
        .look_tag   (look_tag),
        .look_data  (look_data),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_size   (mem_size),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .line_wr    (line_wr)
    );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
    import wtc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        cpu_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [1:0]  mem_size,
    input logic        mem_ack,
    input logic [TAG_W-1:0] look_tag
);

    logic rd_only;
    logic seen_hit;
    assign rd_only  = cpu_ready && cpu_rd && !cpu_wr;
    assign seen_hit = in_window(cpu_addr) && (look_tag == line_tag(cpu_addr)) && (look_tag != TAG_NONE);

    // R12: request held until acknowledged
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req);

    // R12: address stable while waiting
    assert_addr_stable_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> $stable(mem_addr));

    // R12: request drops and the port is ready after the acknowledge
    assert_ack_release_R12: assert property (@(posedge clk) disable iff (rst)
        mem_ack |=> !mem_req && cpu_ready);

    // R8: every store goes to memory and stalls the processor
    assert_store_thru_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_ready && cpu_wr |=> mem_req && mem_we && !cpu_ready);

    // R2: non-cacheable reads reach memory
    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        rd_only && !in_window(cpu_addr) |=> mem_req && !mem_we);

    // R4: fetches are aligned whole words
    assert_fetch_word_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> (mem_addr[1:0] == 2'b00) && (mem_size == SZ_WORD));

    // R5: a hit leaves the memory port idle and the processor ready
    assert_hit_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        rd_only && seen_hit |=> cpu_ready && !mem_req);

    // R11: the empty-marker tag never hits
    assert_marker_miss_R11: assert property (@(posedge clk) disable iff (rst)
        rd_only && in_window(cpu_addr) && (line_tag(cpu_addr) == TAG_NONE) |=> mem_req);

endmodule

bind wt_word_cache wtc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_ack   (mem_ack),
    .look_tag  (look_tag)
);

// File: tb/wt_word_cache_bench.sv
module wt_word_cache_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic [1:0]  cpu_size;
    logic        cpu_rd, cpu_wr, big_endian, cpu_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wt_word_cache u_wt_word_cache (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .big_endian(big_endian), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] image [logic [31:0]];
    int          req_count = 0;
    logic [31:0] last_addr, last_wdata;
    logic [1:0]  last_size;
    logic        last_we;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] al;
        al = {a[31:2], 2'b00};
        if (image.exists(al)) return image[al];
        return {al[15:0] ^ 16'hC3A5, ~al[15:0]};
    endfunction

    task automatic mem_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] w;
        logic [1:0]  l;
        w = mem_word(a);
        l = a[1:0] ^ {big_endian, big_endian};
        if (sz == 2'd0)      w[l*8 +: 8]     = d[7:0];
        else if (sz == 2'd1) w[l[1]*16 +: 16] = d[15:0];
        else                 w = d;
        image[{a[31:2], 2'b00}] = w;
    endtask

    initial begin
        int wait_cnt;
        mem_ack   = 1'b0;
        mem_rdata = '0;
        wait_cnt  = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                wait_cnt++;
                if (wait_cnt == MEM_LAT) begin
                    wait_cnt   = 0;
                    req_count++;
                    last_addr  = mem_addr;
                    last_size  = mem_size;
                    last_we    = mem_we;
                    last_wdata = mem_wdata;
                    if (mem_we) mem_store(mem_addr, mem_size, mem_wdata);
                    else        mem_rdata = mem_word(mem_addr);
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] data;
        bit          miss;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] act_data;
    bit          act_miss;
    event        rsp_ev;

    initial begin
        forever begin
            @(rsp_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected result", act_data, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(act_data == e.data, e.req, "read data", act_data, e.data);
                check(act_miss == e.miss, e.req, "miss flag", {31'b0, act_miss}, {31'b0, e.miss});
            end
        end
    end

    function automatic logic [31:0] expect_lane(input logic [31:0] w, input logic [31:0] a,
                                                input logic [1:0] sz);
        logic [1:0] l;
        l = big_endian ? ~a[1:0] : a[1:0];
        if (sz == 2'd0) return {24'b0, w[l*8 +: 8]};
        if (sz == 2'd1) return {16'b0, w[l[1]*16 +: 16]};
        return w;
    endfunction

    task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                           input bit exp_miss, input string req);
        exp_t e;
        int   c0;
        e.data = expect_lane(mem_word(a), a, sz);
        e.miss = exp_miss;
        e.req  = req;
        exp_q.push_back(e);
        @(negedge clk);
        cpu_addr = a; cpu_size = sz; cpu_rd = 1'b1;
        c0 = req_count;
        @(negedge clk);
        cpu_rd = 1'b0;
        while (!cpu_ready) @(negedge clk);
        act_data = cpu_rdata;
        act_miss = (req_count != c0);
        -> rsp_ev;
    endtask

    task automatic do_write(input logic [31:0] a, input logic [1:0] sz,
                            input logic [31:0] d, input string req);
        int c0;
        @(negedge clk);
        cpu_addr = a; cpu_size = sz; cpu_wdata = d; cpu_wr = 1'b1;
        c0 = req_count;
        @(negedge clk);
        cpu_wr = 1'b0;
        check(!cpu_ready, req, "ready low during store", {31'b0, cpu_ready}, 32'h0);
        while (!cpu_ready) @(negedge clk);
        check(req_count == c0 + 1, req, "one memory write", req_count, c0 + 1);
        check(last_we == 1'b1, req, "write enable", {31'b0, last_we}, 32'h1);
        check(last_addr == a, req, "write address", last_addr, a);
        check(last_size == sz, req, "write size", {30'b0, last_size}, {30'b0, sz});
        check(last_wdata == d, req, "write data", last_wdata, d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_size = 2'd2; cpu_wdata = '0;
        cpu_rd = 1'b0; cpu_wr = 1'b0; big_endian = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(cpu_ready == 1'b1, "R1", "ready after reset", {31'b0, cpu_ready}, 32'h1);
        check(mem_req == 1'b0, "R1", "no request after reset", {31'b0, mem_req}, 32'h0);

        // R1 R4: first access misses and fills; R5: repeat hits
        do_read(32'h1000_0010, 2'd2, 1'b1, "R1");
        check(last_addr == 32'h1000_0010 && !last_we && last_size == 2'd2, "R4",
              "fetch request", last_addr, 32'h1000_0010);
        do_read(32'h1000_0010, 2'd2, 1'b0, "R5");
        // R4: unaligned sub-word miss fetches aligned word
        do_read(32'h1000_0033, 2'd0, 1'b1, "R4");
        check(last_addr == 32'h1000_0030, "R4", "aligned fetch", last_addr, 32'h1000_0030);

        // R6: little-endian lanes on hits
        for (int i = 0; i < 4; i++) do_read(32'h1000_0010 + i, 2'd0, 1'b0, "R6");
        do_read(32'h1000_0010, 2'd1, 1'b0, "R6");
        do_read(32'h1000_0012, 2'd1, 1'b0, "R6");

        // R7: big-endian lanes
        big_endian = 1'b1;
        for (int i = 0; i < 4; i++) do_read(32'h1000_0010 + i, 2'd0, 1'b0, "R7");
        do_read(32'h1000_0010, 2'd1, 1'b0, "R7");
        do_read(32'h1000_0012, 2'd1, 1'b0, "R7");
        do_read(32'h1000_0010, 2'd2, 1'b0, "R7");
        big_endian = 1'b0;

        // R2: outside the window reads always reach memory
        do_read(32'h0000_0040, 2'd2, 1'b1, "R2");
        do_read(32'h0000_0040, 2'd2, 1'b1, "R2");
        do_read(32'h1020_0000, 2'd2, 1'b1, "R2");
        do_read(32'h1020_0000, 2'd2, 1'b1, "R2");
        do_read(32'h0FF0_0100, 2'd2, 1'b1, "R2");
        do_read(32'h0FF0_0100, 2'd2, 1'b1, "R2");
        // R2: second half of the window is cached
        do_read(32'h1010_0020, 2'd2, 1'b1, "R2");
        do_read(32'h1010_0020, 2'd2, 1'b0, "R2");

        // R3: same index, different tag evicts
        do_read(32'h1000_1010, 2'd2, 1'b1, "R3");
        do_read(32'h1000_1010, 2'd2, 1'b0, "R3");
        do_read(32'h1000_0010, 2'd2, 1'b1, "R3");
        do_read(32'h1010_0010, 2'd2, 1'b1, "R3");
        do_read(32'h1000_0010, 2'd2, 1'b1, "R3");

        // R8 R9: word store writes through and refreshes the line
        do_write(32'h1000_0010, 2'd2, 32'hDEAD_BEEF, "R8");
        do_read(32'h1000_0010, 2'd2, 1'b0, "R9");
        do_write(32'h1000_0200, 2'd2, 32'h1234_5678, "R9");
        do_read(32'h1000_0200, 2'd2, 1'b0, "R9");

        // R10: byte and halfword stores empty the line
        do_write(32'h1000_0011, 2'd0, 32'h0000_0077, "R10");
        do_read(32'h1000_0010, 2'd2, 1'b1, "R10");
        do_read(32'h1000_0010, 2'd2, 1'b0, "R10");
        do_write(32'h1000_0012, 2'd1, 32'h0000_ABCD, "R10");
        do_read(32'h1000_0010, 2'd2, 1'b1, "R10");

        // R8: store outside the window
        do_write(32'h2000_0004, 2'd0, 32'h0000_0041, "R8");

        // R11: marker tag region never hits
        do_read(32'h101F_F008, 2'd2, 1'b1, "R11");
        do_read(32'h101F_F008, 2'd2, 1'b1, "R11");
        do_write(32'h101F_F008, 2'd2, 32'h0BAD_F00D, "R11");
        do_read(32'h101F_F008, 2'd2, 1'b1, "R11");

        // R12: port idle once all work is done
        @(negedge clk);
        check(!mem_req && cpu_ready, "R12", "port idle at end", {31'b0, mem_req}, 32'h0);
        check(exp_q.size() == 0, "R4", "all results seen", exp_q.size(), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule